// File: doc/BRIEF.md
# Sled Stepper End-Stop Detector

This block decides whether the sled stepper motor has run into its mechanical end stop. A stepper that still turns produces back-EMF after each reversal of its drive current. A stalled one produces almost none. The block watches the sign of the sled drive command. Every time that sign flips it starts a measurement: it waits a programmable delay, then opens a window of programmable width. During the window it keeps the largest back-EMF magnitude among the strobed samples.

When the window closes, that peak is compared with one of six selectable thresholds:

- A peak below the threshold raises the end-detect flag.
- A peak above the threshold lowers it.
- A peak equal to the threshold leaves it as it was.

The analog back-EMF measurement is outside the block. It receives signed digital samples with a valid strobe. One timing word carries both the delay and the window width.

Top module: `sled_endstop_det`

## Requirements
- R1: While `en` is low, `end_det` is 0 one edge later, no measurement runs, and sign changes of `drive_neg` start nothing.
- R2: With `en` high, a value of `drive_neg` that differs from its value at the previous edge is a polarity reversal and starts a measurement. This holds in both directions.
- R3: `timing_cfg` splits into a delay field D (upper DLY_W bits) and a width field W (lower WIN_W bits). D=0 is valid, and so is the largest value of each field. A reversal seen at edge k gives D delay cycles, then a window of W+1 cycles covering edges k+D+1 through k+D+W+1.
- R4: `thr_sel` values 0 to 5 pick the threshold THR_BASE + sel*THR_STEP, which is 32, 56, 80, 104, 128 or 152 by default. Values 6 and 7 act as 5.
- R5: A sample counts only at a window edge where `bemf_valid` is high. Its magnitude is the absolute value of the two's-complement `bemf_sample`, with -512 counting as 512. The window result is the largest counted magnitude, or 0 if no sample was counted.
- R6: At the last window edge, a result below the threshold sets `end_det` to 1.
- R7: At the last window edge, a result above the threshold clears `end_det` to 0. A result equal to the threshold leaves it unchanged.
- R8: `end_det` changes only at the last edge of a window, or through R1.
- R9: A reversal during the delay or the window restarts the measurement from the delay. The peak gathered so far is discarded and the flag is not updated.
- R10: During and after reset, `end_det` is 0, no measurement runs, and the stored previous sign is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Function enable |
| drive_neg | input | 1 | Sign of the sled drive command (1 = negative) |
| bemf_valid | input | 1 | Strobe marking a valid back-EMF sample |
| bemf_sample | input | 10 | Signed back-EMF sample |
| thr_sel | input | 3 | Threshold level select |
| timing_cfg | input | 12 | Delay field in bits 11:6, window width field in bits 5:0 |
| end_det | output | 1 | End-position detected flag |

## Verification
The flag result of a measurement is due D+W+1 edges after the edge that sees the reversal. The directed checks sample `end_det` at the falling edge just before that edge, where it must still hold its old value, and again at the falling edge just after it, where the new value must be present. Disabling takes effect one edge later and is checked at the next falling edge. A restart moves the due edge to D+W+1 edges after the second reversal; the old due edge is checked for no change. A behavioural model of the phases, counts and peak is compared with `end_det` at every falling edge, both in the directed tests and in a long random run.

// File: rtl/sled_edet_pkg.sv
package sled_edet_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DELAY  = 2'd1,
    PH_WINDOW = 2'd2
  } phase_e;
endpackage

// File: rtl/sled_edet_xing.sv
module sled_edet_xing (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic drive_neg,
  output logic reversal
);
  logic sign_q;
  logic sign_d;

  always_comb begin
    sign_d = drive_neg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sign_q <= 1'b0;
    else        sign_q <= sign_d;
  end

  assign reversal = en & (drive_neg ^ sign_q);

  // R2: once the sign has been sampled, a repeated value is no reversal
  p_steady_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(drive_neg) && en) |=> (!$changed(drive_neg) |-> !reversal));
endmodule

// File: rtl/sled_edet_timer.sv
module sled_edet_timer
  import sled_edet_pkg::*;
#(
  parameter int DLY_W = 6,
  parameter int WIN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             reversal,
  input  logic [DLY_W-1:0] dly,
  input  logic [WIN_W-1:0] win,
  output logic             win_open,
  output logic             win_last
);
  localparam int CNT_W = (DLY_W > WIN_W) ? DLY_W : WIN_W;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else if (reversal) begin
      if (dly == '0) begin
        ph_d  = PH_WINDOW;
        cnt_d = CNT_W'(win);
      end else begin
        ph_d  = PH_DELAY;
        cnt_d = CNT_W'(dly) - CNT_W'(1);
      end
    end else begin
      unique case (ph_q)
        PH_DELAY: begin
          if (cnt_q == '0) begin
            ph_d  = PH_WINDOW;
            cnt_d = CNT_W'(win);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        PH_WINDOW: begin
          if (cnt_q == '0) ph_d = PH_IDLE;
          else             cnt_d = cnt_q - CNT_W'(1);
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign win_open = (ph_q == PH_WINDOW);
  assign win_last = en & win_open & (cnt_q == '0) & ~reversal;

  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ph_q == PH_IDLE));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reversal |=> (ph_q != PH_IDLE));

  p_delay_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !reversal && ph_q == PH_DELAY && cnt_q != '0)
      |=> (ph_q == PH_DELAY && cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/sled_edet_level.sv
module sled_edet_level #(
  parameter int MW       = 10,
  parameter int LEVELS   = 6,
  parameter int THR_BASE = 32,
  parameter int THR_STEP = 24,
  parameter int SEL_W    = $clog2(LEVELS)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [MW-1:0]    thr
);
  logic [MW-1:0]    lvl [LEVELS];
  logic [SEL_W-1:0] idx;

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    assign lvl[i] = MW'(THR_BASE + i * THR_STEP);
  end

  always_comb begin
    if (int'(sel) >= LEVELS) idx = SEL_W'(LEVELS - 1);
    else                     idx = sel;
    thr = lvl[idx];
  end

  // R4: the selected level never exceeds the top level
  always_comb begin
    p_thr_top_r4: assert (thr <= MW'(THR_BASE + (LEVELS - 1) * THR_STEP));
  end
endmodule

// File: rtl/sled_edet_judge.sv
module sled_edet_judge #(
  parameter int MW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 reversal,
  input  logic                 win_open,
  input  logic                 win_last,
  input  logic                 smp_valid,
  input  logic signed [MW-1:0] smp,
  input  logic [MW-1:0]        thr,
  output logic                 flag
);
  logic [MW-1:0] mag;
  logic [MW-1:0] cand;
  logic [MW-1:0] pk_all;
  logic [MW-1:0] peak_q, peak_d;
  logic          flag_q, flag_d;

  always_comb begin
    mag    = smp[MW-1] ? (~smp + MW'(1)) : smp;
    cand   = (smp_valid && win_open) ? mag : '0;
    pk_all = (cand > peak_q) ? cand : peak_q;
  end

  always_comb begin
    if (!en || reversal || !win_open || win_last) peak_d = '0;
    else                                          peak_d = pk_all;
  end

  always_comb begin
    flag_d = flag_q;
    if (!en) begin
      flag_d = 1'b0;
    end else if (win_last) begin
      if (pk_all < thr)      flag_d = 1'b1;
      else if (pk_all > thr) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
      flag_q <= 1'b0;
    end else begin
      peak_q <= peak_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !win_last) |=> $stable(flag_q));

  p_flag_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag_q);

  p_peak_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && win_open && !reversal && !win_last) |=> (peak_q >= $past(peak_q)));

  p_set_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && pk_all < thr) |=> flag_q);
endmodule

// File: rtl/sled_endstop_det.sv
module sled_endstop_det #(
  parameter int BEMF_W   = 10,
  parameter int DLY_W    = 6,
  parameter int WIN_W    = 6,
  parameter int LEVELS   = 6,
  parameter int THR_BASE = 32,
  parameter int THR_STEP = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     drive_neg,
  input  logic                     bemf_valid,
  input  logic signed [BEMF_W-1:0] bemf_sample,
  input  logic [$clog2(LEVELS)-1:0] thr_sel,
  input  logic [DLY_W+WIN_W-1:0]   timing_cfg,
  output logic                     end_det
);
  localparam int SEL_W = $clog2(LEVELS);

  logic              reversal;
  logic              win_open;
  logic              win_last;
  logic [BEMF_W-1:0] thr;
  logic [DLY_W-1:0]  dly_f;
  logic [WIN_W-1:0]  win_f;

  assign dly_f = timing_cfg[DLY_W+WIN_W-1:WIN_W];
  assign win_f = timing_cfg[WIN_W-1:0];

  sled_edet_xing u_xing (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .drive_neg (drive_neg),
    .reversal  (reversal)
  );

  sled_edet_timer #(.DLY_W(DLY_W), .WIN_W(WIN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .reversal (reversal),
    .dly      (dly_f),
    .win      (win_f),
    .win_open (win_open),
    .win_last (win_last)
  );

  sled_edet_level #(
    .MW(BEMF_W), .LEVELS(LEVELS), .THR_BASE(THR_BASE),
    .THR_STEP(THR_STEP), .SEL_W(SEL_W)
  ) u_level (
    .sel (thr_sel),
    .thr (thr)
  );

  sled_edet_judge #(.MW(BEMF_W)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .reversal  (reversal),
    .win_open  (win_open),
    .win_last  (win_last),
    .smp_valid (bemf_valid),
    .smp       (bemf_sample),
    .thr       (thr),
    .flag      (end_det)
  );

  // R10: reset leaves the flag low
  p_reset_low_r10: assert property (@(posedge clk)
    !rst_n |=> !end_det);
endmodule

// File: tb/tb_sled_endstop_det.sv
`timescale 1ns/1ps
module tb_sled_endstop_det;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              en;
  logic              drive_neg;
  logic              bemf_valid;
  logic signed [9:0] bemf_sample;
  logic [2:0]        thr_sel;
  logic [11:0]       timing_cfg;
  logic              end_det;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  bit m_prev;
  int m_phase;   // 0 idle, 1 delay, 2 window
  int m_cnt;
  int m_peak;
  bit m_flag;

  always #4 clk = ~clk;

  sled_endstop_det dut (
    .clk(clk), .rst_n(rst_n), .en(en), .drive_neg(drive_neg),
    .bemf_valid(bemf_valid), .bemf_sample(bemf_sample),
    .thr_sel(thr_sel), .timing_cfg(timing_cfg), .end_det(end_det)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int thr_of(input int sel);
    int i;
    i = (sel > 5) ? 5 : sel;
    return 32 + 24 * i;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_phase = 0; m_cnt = 0; m_peak = 0; m_flag = 0;
    end else begin
      bit rev;
      int d, w, s, mag, pk, th;
      rev = en && (drive_neg != m_prev);
      m_prev = drive_neg;
      d = int'(timing_cfg[11:6]);
      w = int'(timing_cfg[5:0]);
      if (!en) begin
        m_phase = 0; m_cnt = 0; m_peak = 0; m_flag = 0;
      end else if (rev) begin
        m_peak = 0;
        if (d == 0) begin m_phase = 2; m_cnt = w; end
        else        begin m_phase = 1; m_cnt = d - 1; end
      end else if (m_phase == 1) begin
        if (m_cnt == 0) begin m_phase = 2; m_cnt = w; m_peak = 0; end
        else m_cnt--;
      end else if (m_phase == 2) begin
        s   = bemf_sample;
        mag = s < 0 ? -s : s;
        pk  = (bemf_valid && mag > m_peak) ? mag : m_peak;
        if (m_cnt == 0) begin
          th = thr_of(int'(thr_sel));
          if (pk < th)      m_flag = 1;
          else if (pk > th) m_flag = 0;
          m_phase = 0; m_peak = 0;
        end else begin
          m_peak = pk; m_cnt--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) chk(end_det == m_flag, "R6/R7 model", end_det, m_flag);
  end

  // one measurement: reversal, then D+W+1 edges to the result
  task automatic measure(input int val, input bit vld, input int d, input int w,
                         input bit exp, input string req);
    bit pre;
    @(negedge clk);
    pre         = end_det;
    timing_cfg  = {6'(d), 6'(w)};
    bemf_sample = 10'(val);
    bemf_valid  = vld;
    drive_neg   = ~drive_neg;
    @(posedge clk);
    repeat (d + w) @(posedge clk);
    @(negedge clk);
    chk(end_det == pre, "R8 no early change", end_det, pre);
    @(posedge clk);
    @(negedge clk);
    chk(end_det == exp, req, end_det, exp);
  endtask

  task automatic restart_case(input int first, input int second, input bit exp);
    @(negedge clk);
    timing_cfg  = {6'd2, 6'd5};
    bemf_sample = 10'(first);
    bemf_valid  = 1'b1;
    drive_neg   = ~drive_neg;
    @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    bemf_sample = 10'(second);
    drive_neg   = ~drive_neg;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(end_det == 1'b0, "R9 old window end ignored", end_det, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(end_det == 1'b0, "R9 before restarted end", end_det, 0);
    @(posedge clk);
    @(negedge clk);
    chk(end_det == exp, "R9 restarted result", end_det, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; drive_neg = 1'b0; bemf_valid = 1'b0;
    bemf_sample = '0; thr_sel = 3'd2; timing_cfg = '0;
    repeat (3) @(negedge clk);
    chk(end_det == 1'b0, "R10 in reset", end_det, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(end_det == 1'b0, "R10 after reset", end_det, 0);
    en = 1'b1;
    repeat (3) @(negedge clk);

    measure(10, 1, 3, 4, 1, "R6 low bemf sets");
    measure(-200, 1, 3, 4, 0, "R7 high bemf clears");
    measure(10, 1, 2, 2, 1, "R2 reversal both ways");
    measure(80, 1, 3, 4, 1, "R7 equal holds one");
    measure(300, 1, 1, 1, 0, "R7 clear");
    measure(-80, 1, 3, 4, 0, "R7 equal holds zero");

    thr_sel = 3'd7;
    measure(151, 1, 3, 4, 1, "R4 sel 7 as level 5");
    thr_sel = 3'd6;
    measure(153, 1, 3, 4, 0, "R4 sel 6 as level 5");
    thr_sel = 3'd0;
    measure(31, 1, 3, 4, 1, "R4 level 0");
    measure(33, 1, 3, 4, 0, "R4 level 0 above");
    thr_sel = 3'd2;

    measure(500, 0, 3, 4, 1, "R5 invalid samples ignored");
    measure(-512, 1, 3, 4, 0, "R5 most negative magnitude");
    measure(10, 1, 0, 0, 1, "R3 zero delay one-cycle window");
    measure(-300, 1, 63, 63, 0, "R3 largest delay and window");

    restart_case(5, 300, 0);
    restart_case(300, 5, 1);

    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(end_det == 1'b0, "R1 disable clears", end_det, 0);
    bemf_sample = 10'sd3;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      drive_neg = ~drive_neg;
    end
    repeat (100) @(negedge clk);
    chk(end_det == 1'b0, "R1 reversals ignored while off", end_det, 0);
    en = 1'b1;
    repeat (150) @(negedge clk);
    chk(end_det == 1'b0, "R1 no stale measurement", end_det, 0);

    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(19, 0) == 0) drive_neg = ~drive_neg;
      en          = ($urandom_range(199, 0) != 0);
      bemf_valid  = $urandom_range(1, 0) == 1;
      bemf_sample = 10'($signed($urandom_range(400, 0)) - 200);
      if ($urandom_range(49, 0) == 0) thr_sel = 3'($urandom_range(7, 0));
      if ($urandom_range(49, 0) == 0)
        timing_cfg = {6'($urandom_range(7, 0)), 6'($urandom_range(7, 0))};
    end
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule